// File: doc/BRIEF.md
# Receive frame length error classifier

This block sits beside an Ethernet receive path and watches each frame as a stream of bytes. A start marker opens a frame and an end marker closes it. The block counts the accepted bytes and takes the 16-bit length/type field from the untagged header. When the frame ends, it combines the byte count, that field, the CRC result reported on the last byte and two configuration bits into one 4-bit error-type code, an error-summary flag and the frame's total length.

The code covers four conditions. A bad CRC, an oversized frame, a frame whose size disagrees with its length field, and a short frame whose CRC is good. The size limit depends on a jumbo-enable input and a tagged-frame allowance input. The oversize status is a report only; the reported length is the full count.

Top module: `rx_len_classifier`

## Requirements
- R1: While reset is active, and directly after it, `res_valid`, `res_err_type`, `res_err_sum` and `res_frame_len` are all zero.
- R2: `res_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the end-marked byte. `res_frame_len` then equals the number of accepted bytes from the start-marked byte to the end-marked byte, both included. Between results, `res_err_type`, `res_err_sum` and `res_frame_len` keep their last values.
- R3: The byte count saturates at 16383. A longer frame reports a length of 16383.
- R4: When `crc_ok` is low on the end-marked byte, the code is 4'b0011 (CRC error). This holds whatever other condition applies.
- R5: When there is no CRC error and the length exceeds the limit, the code is 4'b0100 (giant). The limit is 1518, or 9018 when `cfg_jumbo_en` is high, plus 4 when `cfg_tag_allow` is high.
- R6: The length/type field is byte 12 (most significant) and byte 13 of the frame, counted from 0 at the start-marked byte. The length rules of R7 and R8 apply only when the frame reaches byte 13 and the field is below 1500. Values of 1500 or more are type values and are never checked.
- R7: When the field is below 46 and the length is less than the field plus 18, the code is 4'b1001 (length error), unless R4 or R5 applies.
- R8: When the field is 46 to 1499 and the length differs from the field plus 18, the code is 4'b1001, unless R4 or R5 applies.
- R9: A frame shorter than 64 bytes with a good CRC gets code 4'b1010 (good runt), unless R4, R5, R7 or R8 applies.
- R10: `res_err_sum` is high exactly when the code is nonzero. A frame with no error reports code 4'b0000.
- R11: Bytes with `in_valid` low are ignored. Valid bytes outside a frame (before any start marker, or after an end marker) are ignored. A start marker in the middle of a frame discards that frame and begins counting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_eof | input | 1 | Current byte is the last of a frame |
| in_data | input | 8 | Received byte |
| crc_ok | input | 1 | CRC check passed; sampled with the end-marked byte |
| cfg_jumbo_en | input | 1 | Raises the size limit to the jumbo value |
| cfg_tag_allow | input | 1 | Adds 4 bytes to the size limit for tagged frames |
| res_valid | output | 1 | One-cycle strobe: result fields are new |
| res_err_type | output | 4 | Error-type code |
| res_err_sum | output | 1 | Any error reported |
| res_frame_len | output | 14 | Total accepted bytes of the frame, saturated |

## Verification
All results come from one register stage. The classification of an end-marked byte that is driven before rising edge k is visible from just after edge k and is compared at the following falling edge. The bench drives inputs only on falling edges. A behavioural model updates its expected outputs on each rising edge from the bytes it has queued. The outputs are compared with it on every falling edge, so a result that is one cycle early or late, or a strobe that lasts too long, is caught in the exact cycle. Directed checks with hand-computed codes and lengths are also made at the falling edge after each frame's last byte. They cover the 46-byte and 1500 boundaries, each size limit, the priority order, gaps in the stream, restarts and saturation.

// File: rtl/rxlc_pkg.sv
package rxlc_pkg;

    typedef enum logic [3:0] {
        ERR_NONE   = 4'b0000,
        ERR_CRC    = 4'b0011,
        ERR_GIANT  = 4'b0100,
        ERR_LENGTH = 4'b1001,
        ERR_RUNT   = 4'b1010
    } err_code_e;

endpackage

// File: rtl/rxlc_byte_counter.sv
module rxlc_byte_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             beat_take,
    output logic             beat_last,
    output logic [CNT_W-1:0] beat_idx,
    output logic [CNT_W-1:0] beat_total
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        beat_take  = in_valid & (in_sof | st_q.active);
        beat_last  = beat_take & in_eof;
        beat_idx   = in_sof ? '0 : st_q.cnt;
        beat_total = (beat_idx == CNT_MAX) ? CNT_MAX : beat_idx + 1'b1;
        st_d       = st_q;
        if (beat_take) begin
            st_d.active = ~in_eof;
            st_d.cnt    = beat_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxlc_len_field.sv
module rxlc_len_field #(
    parameter int CNT_W     = 14,
    parameter int FIELD_POS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_take,
    input  logic             in_sof,
    input  logic [CNT_W-1:0] beat_idx,
    input  logic [7:0]       in_data,
    output logic [15:0]      field_val,
    output logic             field_ok
);

    localparam logic [CNT_W-1:0] POS_HI = CNT_W'(FIELD_POS);
    localparam logic [CNT_W-1:0] POS_LO = CNT_W'(FIELD_POS + 1);

    typedef struct packed {
        logic       full;
        logic [7:0] hi;
        logic [7:0] lo;
    } fld_st_t;

    fld_st_t st_d, st_q;
    logic    lo_now;

    always_comb begin
        lo_now = beat_take & (beat_idx == POS_LO);
        st_d   = st_q;
        if (beat_take & in_sof) begin
            st_d.full = 1'b0;
        end
        if (beat_take & (beat_idx == POS_HI)) begin
            st_d.hi = in_data;
        end
        if (lo_now) begin
            st_d.lo   = in_data;
            st_d.full = 1'b1;
        end
        field_ok  = (st_q.full & ~in_sof) | lo_now;
        field_val = lo_now ? {st_q.hi, in_data} : {st_q.hi, st_q.lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxlc_classify.sv
module rxlc_classify
    import rxlc_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int STD_MAX     = 1518,
    parameter int JUMBO_MAX   = 9018,
    parameter int TAG_EXTRA   = 4,
    parameter int RUNT_MIN    = 64,
    parameter int TYPE_SPLIT  = 1500,
    parameter int SHORT_FIELD = 46,
    parameter int OVERHEAD    = 18
) (
    input  logic [CNT_W-1:0] total,
    input  logic             crc_ok,
    input  logic [15:0]      field_val,
    input  logic             field_ok,
    input  logic             cfg_jumbo_en,
    input  logic             cfg_tag_allow,
    output err_code_e        code,
    output logic             err_sum
);

    localparam int CMP_W = ((CNT_W > 16) ? CNT_W : 16) + 2;

    logic [CMP_W-1:0] tot_x, lim_x, fld_x, want_x;
    logic             crc_f, giant_f, len_f, runt_f, is_len;

    always_comb begin
        tot_x  = CMP_W'(total);
        fld_x  = CMP_W'(field_val);
        want_x = fld_x + CMP_W'(OVERHEAD);
        lim_x  = (cfg_jumbo_en ? CMP_W'(JUMBO_MAX) : CMP_W'(STD_MAX))
               + (cfg_tag_allow ? CMP_W'(TAG_EXTRA) : '0);

        crc_f   = ~crc_ok;
        giant_f = tot_x > lim_x;
        is_len  = field_ok & (fld_x < CMP_W'(TYPE_SPLIT));
        if (fld_x < CMP_W'(SHORT_FIELD)) begin
            len_f = is_len & (tot_x < want_x);
        end else begin
            len_f = is_len & (tot_x != want_x);
        end
        runt_f  = crc_ok & (tot_x < CMP_W'(RUNT_MIN));

        if (crc_f)        code = ERR_CRC;
        else if (giant_f) code = ERR_GIANT;
        else if (len_f)   code = ERR_LENGTH;
        else if (runt_f)  code = ERR_RUNT;
        else              code = ERR_NONE;

        err_sum = crc_f | giant_f | len_f | runt_f;
    end

endmodule

// File: rtl/rx_len_classifier.sv
module rx_len_classifier
    import rxlc_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int STD_MAX     = 1518,
    parameter int JUMBO_MAX   = 9018,
    parameter int TAG_EXTRA   = 4,
    parameter int RUNT_MIN    = 64,
    parameter int TYPE_SPLIT  = 1500,
    parameter int SHORT_FIELD = 46,
    parameter int OVERHEAD    = 18,
    parameter int FIELD_POS   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             crc_ok,
    input  logic             cfg_jumbo_en,
    input  logic             cfg_tag_allow,
    output logic             res_valid,
    output logic [3:0]       res_err_type,
    output logic             res_err_sum,
    output logic [CNT_W-1:0] res_frame_len
);

    typedef struct packed {
        logic             valid;
        logic [3:0]       code;
        logic             sum;
        logic [CNT_W-1:0] len;
    } res_st_t;

    logic             beat_take, beat_last;
    logic [CNT_W-1:0] beat_idx, beat_total;
    logic [15:0]      field_val;
    logic             field_ok;
    err_code_e        code;
    logic             err_sum;
    res_st_t          res_d, res_q;

    rxlc_byte_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .beat_take  (beat_take),
        .beat_last  (beat_last),
        .beat_idx   (beat_idx),
        .beat_total (beat_total)
    );

    rxlc_len_field #(.CNT_W(CNT_W), .FIELD_POS(FIELD_POS)) i_fld (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_take (beat_take),
        .in_sof    (in_sof),
        .beat_idx  (beat_idx),
        .in_data   (in_data),
        .field_val (field_val),
        .field_ok  (field_ok)
    );

    rxlc_classify #(
        .CNT_W       (CNT_W),
        .STD_MAX     (STD_MAX),
        .JUMBO_MAX   (JUMBO_MAX),
        .TAG_EXTRA   (TAG_EXTRA),
        .RUNT_MIN    (RUNT_MIN),
        .TYPE_SPLIT  (TYPE_SPLIT),
        .SHORT_FIELD (SHORT_FIELD),
        .OVERHEAD    (OVERHEAD)
    ) i_cls (
        .total         (beat_total),
        .crc_ok        (crc_ok),
        .field_val     (field_val),
        .field_ok      (field_ok),
        .cfg_jumbo_en  (cfg_jumbo_en),
        .cfg_tag_allow (cfg_tag_allow),
        .code          (code),
        .err_sum       (err_sum)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = beat_last;
        if (beat_last) begin
            res_d.code = code;
            res_d.sum  = err_sum;
            res_d.len  = beat_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid     = res_q.valid;
    assign res_err_type  = res_q.code;
    assign res_err_sum   = res_q.sum;
    assign res_frame_len = res_q.len;

endmodule

// File: rtl/rxlc_checker.sv
module rxlc_checker #(
    parameter int CNT_W    = 14,
    parameter int STD_MAX  = 1518,
    parameter int RUNT_MIN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             crc_ok,
    input logic             res_valid,
    input logic [3:0]       res_err_type,
    input logic             res_err_sum,
    input logic [CNT_W-1:0] res_frame_len
);

    AST_STROBE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid & in_eof)); // R2

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_frame_len) && $stable(res_err_type))); // R2

    AST_CRC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(crc_ok)) |-> (res_err_type == 4'b0011)); // R4

    AST_GIANT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err_type == 4'b0100) |-> (32'(res_frame_len) > STD_MAX)); // R5

    AST_RUNT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err_type == 4'b1010) |-> (32'(res_frame_len) < RUNT_MIN)); // R9

    AST_SUM_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_err_sum == (res_err_type != 4'b0000))); // R10

endmodule

bind rx_len_classifier rxlc_checker #(
    .CNT_W    (CNT_W),
    .STD_MAX  (STD_MAX),
    .RUNT_MIN (RUNT_MIN)
) i_rxlc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_eof        (in_eof),
    .crc_ok        (crc_ok),
    .res_valid     (res_valid),
    .res_err_type  (res_err_type),
    .res_err_sum   (res_err_sum),
    .res_frame_len (res_frame_len)
);

// File: tb/test_rx_len_classifier.sv
module test_rx_len_classifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        crc_ok = 1'b1, cfg_jumbo_en = 1'b0, cfg_tag_allow = 1'b0;
    logic        res_valid, res_err_sum;
    logic [3:0]  res_err_type;
    logic [13:0] res_frame_len;

    int n_chk = 0, n_bad = 0, cyc = 0;

    rx_len_classifier i_rx_len_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .crc_ok(crc_ok),
        .cfg_jumbo_en(cfg_jumbo_en), .cfg_tag_allow(cfg_tag_allow),
        .res_valid(res_valid), .res_err_type(res_err_type),
        .res_err_sum(res_err_sum), .res_frame_len(res_frame_len)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    byte unsigned q[$];
    bit   m_act = 0;
    bit   exp_valid = 0, exp_sum = 0;
    int   exp_code = 0, exp_len = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_act = 0; exp_valid = 0; exp_code = 0; exp_sum = 0; exp_len = 0;
        end else begin
            exp_valid = 0;
            if (in_valid && (in_sof || m_act)) begin
                if (in_sof) q.delete();
                q.push_back(in_data);
                m_act = !in_eof;
                if (in_eof) begin
                    int sz, lim, f;
                    bit lerr;
                    sz   = q.size();
                    exp_len = (sz > 16383) ? 16383 : sz;
                    lim  = (cfg_jumbo_en ? 9018 : 1518) + (cfg_tag_allow ? 4 : 0);
                    lerr = 0;
                    if (sz >= 14) begin
                        f = int'(q[12]) * 256 + int'(q[13]);
                        if (f < 46)        lerr = exp_len < f + 18;
                        else if (f < 1500) lerr = exp_len != f + 18;
                    end
                    if (!crc_ok)           exp_code = 3;
                    else if (exp_len > lim) exp_code = 4;
                    else if (lerr)         exp_code = 9;
                    else if (exp_len < 64) exp_code = 10;
                    else                   exp_code = 0;
                    exp_sum   = (exp_code != 0);
                    exp_valid = 1;
                end
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) begin
            n_chk++;
            if (res_valid !== exp_valid) begin
                n_bad++;
                $display("FAIL R2 strobe: got %0b exp %0b at cycle %0d", res_valid, exp_valid, cyc);
            end
            if (res_err_type !== 4'(exp_code) || res_err_sum !== exp_sum) begin
                n_bad++;
                $display("FAIL R10 code/sum: got %b/%0b exp %b/%0b", res_err_type, res_err_sum, 4'(exp_code), exp_sum);
            end
            if (res_frame_len !== 14'(exp_len)) begin
                n_bad++;
                $display("FAIL R2 length: got %0d exp %0d", res_frame_len, exp_len);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] byte_at(int i, int lf);
        if (i == 12) return 8'(lf >> 8);
        if (i == 13) return 8'(lf);
        return 8'(i * 7);
    endfunction

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
    endtask

    task automatic send_bytes(int n, int lf, bit crc, bit gaps, bit close);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 2)) idle();
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = close && (i == n - 1);
            in_data = byte_at(i, lf); crc_ok = crc;
        end
        idle();
    endtask

    task automatic check(string tag, int code, int len);
        n_chk++;
        if (res_valid !== 1'b1 || res_err_type !== 4'(code) || res_frame_len !== 14'(len)
            || res_err_sum !== (code != 0)) begin
            n_bad++;
            $display("FAIL %s: got v=%0b code=%b sum=%0b len=%0d exp v=1 code=%b sum=%0b len=%0d",
                     tag, res_valid, res_err_type, res_err_sum, res_frame_len,
                     4'(code), (code != 0), len);
        end
    endtask

    task automatic frame(string tag, int n, int lf, bit crc, int code);
        send_bytes(n, lf, crc, 0, 1);
        check(tag, code, n > 16383 ? 16383 : n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_valid !== 0 || res_err_type !== 0 || res_err_sum !== 0 || res_frame_len !== 0) begin
            n_bad++;
            $display("FAIL R1: got %0b %b %0b %0d exp all zero", res_valid, res_err_type, res_err_sum, res_frame_len);
        end
        rst_n = 1;
        idle();

        frame("R6 type value", 64, 16'h0800, 1, 0);
        frame("R9 runt", 60, 16'h0800, 1, 10);
        frame("R8 exact 46", 64, 46, 1, 0);
        frame("R8 mismatch 46", 65, 46, 1, 9);
        frame("R7 long enough", 64, 40, 1, 0);
        frame("R7 too short", 50, 40, 1, 9);
        frame("R8 1499 mismatch", 60, 1499, 1, 9);
        frame("R8 1499 exact", 1517, 1499, 1, 0);
        frame("R6 1500 unchecked", 100, 1500, 1, 0);
        frame("R6 no field short", 10, 0, 1, 10);
        frame("R9 one byte", 1, 0, 1, 10);
        frame("R5 limit ok", 1518, 16'h0800, 1, 0);
        frame("R5 giant", 1519, 16'h0800, 1, 4);
        frame("R4 crc short", 60, 16'h0800, 0, 3);
        frame("R4 crc giant", 2000, 16'h0800, 0, 3);
        cfg_tag_allow = 1;
        frame("R5 tagged ok", 1522, 16'h0800, 1, 0);
        frame("R5 tagged giant", 1523, 16'h0800, 1, 4);
        cfg_tag_allow = 0; cfg_jumbo_en = 1;
        frame("R5 jumbo ok", 9018, 16'h0800, 1, 0);
        frame("R5 jumbo giant", 9019, 16'h0800, 1, 4);
        frame("R3 saturate", 16500, 16'h0800, 1, 4);
        cfg_jumbo_en = 0;

        // R11: stray bytes outside frames, gaps, restart mid-frame
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1; in_sof = 0; in_eof = 0; in_data = 8'hAA;
        end
        idle();
        send_bytes(64, 46, 1, 1, 1);
        check("R11 gaps", 0, 64);
        send_bytes(20, 0, 1, 0, 0);
        frame("R11 restart", 64, 46, 1, 0);

        // R2: fields held and strobe dropped one cycle later
        @(negedge clk);
        n_chk++;
        if (res_valid !== 0 || res_frame_len !== 14'd64) begin
            n_bad++;
            $display("FAIL R2 hold: got v=%0b len=%0d exp v=0 len=64", res_valid, res_frame_len);
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule